// File: doc/BRIEF.md
# Sector Erase Batch Timer

This block sits on the device side of a flash array and gathers sector erase requests into a single erase batch. The first sector command opens an acceptance window. Each further sector command sets its bit in a per-sector selection mask and restarts the window from its full length. When the window closes with no new sector command, the block pulses an erase-start output. It also raises an erase-active status bit, which reads 0 while sectors are still being collected.

After erasing has begun, the block accepts only a suspend request. It rejects every other command strobe with a one-cycle flag. A suspended erase holds its mask and status until a resume strobe arrives. A chip erase command skips the window and starts at once with every sector selected. An erase-finished input clears the mask and returns the block to idle. The erase algorithm itself and the host bus decode are handled elsewhere.

Top module: `sect_erase_batcher`

## Requirements
- R1: After reset, every output is 0: the mask, erase-active, erase-start, reject and suspended.
- R2: In idle, a sector command with index i sets mask bit i (bit 0 is sector 0) on the next cycle. Erase-active stays 0 while the window is open.
- R3: Erase-active rises exactly WINDOW_CYCLES cycles after the edge that accepted the last sector command. Erase-start is high for that one cycle only.
- R4: A sector command during the window ORs its bit into the mask and restarts the full window. This also holds when it arrives on the very edge at which the window would have closed.
- R5: In idle, a chip erase command sets all mask bits and erase-active on the next cycle, with a one-cycle erase-start and no window.
- R6: While erasing, sector, chip, generic and resume strobes have no effect on the mask or status. Each one raises reject for exactly one cycle.
- R7: While erasing, a suspend strobe raises suspended on the next cycle and holds the mask and erase-active. While suspended, erase-finished is ignored and any strobe other than resume is rejected. Resume clears suspended.
- R8: While erasing and not suspended, erase-finished clears the mask and erase-active on the next cycle. It takes priority over a suspend strobe in the same cycle.
- R9: During the window, chip, generic, suspend and resume strobes raise reject for one cycle. They leave the mask unchanged and do not move the window's closing cycle.
- R10: In idle, generic, suspend and resume strobes cause no output change and no reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_cmd_i | input | 1 | Sector erase command strobe |
| sec_idx_i | input | IDX_W | Sector index for the sector command |
| chip_cmd_i | input | 1 | Chip erase command strobe |
| susp_cmd_i | input | 1 | Erase suspend strobe |
| resume_cmd_i | input | 1 | Erase resume strobe |
| other_cmd_i | input | 1 | Any other command strobe |
| erase_done_i | input | 1 | Erase-finished indication |
| erasing_o | output | 1 | Erase-active status bit (0 while collecting) |
| sel_mask_o | output | NUM_SECTORS | Selected sectors, one bit each |
| start_pulse_o | output | 1 | One-cycle erase start |
| cmd_reject_o | output | 1 | One-cycle flag for an ignored command |
| suspended_o | output | 1 | Erase is suspended |

## Verification
Two events can meet on one clock edge: the window running out and a fresh sector command arriving. The bench provokes this by issuing a sector command exactly WINDOW_CYCLES cycles after the previous one was taken. It then expects the command to win. The mask gains the new bit, erase-start stays low on that edge, and erase-active rises one full window later. A second meeting is erase-finished together with a suspend strobe. Here the bench expects the block to return to idle rather than become suspended.

// File: rtl/sect_erase_pkg.sv
package sect_erase_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_LOCKED  = 2'd2,
        ST_HELD    = 2'd3
    } batch_state_e;

endpackage

// File: rtl/sect_onehot_dec.sv
module sect_onehot_dec #(
    parameter int NUM_SECTORS = 8,
    parameter int IDX_W       = 3
) (
    input  logic [IDX_W-1:0]       idx_i,
    output logic [NUM_SECTORS-1:0] onehot_o
);

    for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_bit
        assign onehot_o[g] = (idx_i == IDX_W'(g));
    end

endmodule

// File: rtl/sect_window_timer.sv
module sect_window_timer #(
    parameter int WINDOW_CYCLES = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic zero_o
);

    localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WINDOW_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = RELOAD;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sect_erase_batcher.sv
module sect_erase_batcher
    import sect_erase_pkg::*;
#(
    parameter  int NUM_SECTORS   = 8,
    parameter  int WINDOW_CYCLES = 12500,
    localparam int IDX_W         = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sec_cmd_i,
    input  logic [IDX_W-1:0]       sec_idx_i,
    input  logic                   chip_cmd_i,
    input  logic                   susp_cmd_i,
    input  logic                   resume_cmd_i,
    input  logic                   other_cmd_i,
    input  logic                   erase_done_i,
    output logic                   erasing_o,
    output logic [NUM_SECTORS-1:0] sel_mask_o,
    output logic                   start_pulse_o,
    output logic                   cmd_reject_o,
    output logic                   suspended_o
);

    typedef struct packed {
        batch_state_e           state;
        logic [NUM_SECTORS-1:0] mask;
        logic                   start;
        logic                   reject;
    } ctl_t;

    ctl_t                   ctl_d, ctl_q;
    logic [NUM_SECTORS-1:0] sec_onehot;
    logic                   win_load;
    logic                   win_zero;

    sect_onehot_dec #(
        .NUM_SECTORS (NUM_SECTORS),
        .IDX_W       (IDX_W)
    ) dec_i (
        .idx_i    (sec_idx_i),
        .onehot_o (sec_onehot)
    );

    sect_window_timer #(
        .WINDOW_CYCLES (WINDOW_CYCLES)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (win_load),
        .run_i  (ctl_q.state == ST_COLLECT),
        .zero_o (win_zero)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.start  = 1'b0;
        ctl_d.reject = 1'b0;
        win_load     = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (sec_cmd_i) begin
                    ctl_d.state = ST_COLLECT;
                    ctl_d.mask  = ctl_q.mask | sec_onehot;
                    win_load    = 1'b1;
                end else if (chip_cmd_i) begin
                    ctl_d.state = ST_LOCKED;
                    ctl_d.mask  = '1;
                    ctl_d.start = 1'b1;
                end
            end
            ST_COLLECT: begin
                ctl_d.reject = chip_cmd_i | other_cmd_i | susp_cmd_i | resume_cmd_i;
                if (sec_cmd_i) begin
                    ctl_d.mask = ctl_q.mask | sec_onehot;
                    win_load   = 1'b1;
                end else if (win_zero) begin
                    ctl_d.state = ST_LOCKED;
                    ctl_d.start = 1'b1;
                end
            end
            ST_LOCKED: begin
                if (erase_done_i) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.mask  = '0;
                end else begin
                    ctl_d.reject = sec_cmd_i | chip_cmd_i | other_cmd_i | resume_cmd_i;
                    if (susp_cmd_i) begin
                        ctl_d.state = ST_HELD;
                    end
                end
            end
            ST_HELD: begin
                ctl_d.reject = sec_cmd_i | chip_cmd_i | other_cmd_i | susp_cmd_i;
                if (resume_cmd_i) begin
                    ctl_d.state = ST_LOCKED;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, mask: '0, start: 1'b0, reject: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign erasing_o     = (ctl_q.state == ST_LOCKED) || (ctl_q.state == ST_HELD);
    assign suspended_o   = (ctl_q.state == ST_HELD);
    assign sel_mask_o    = ctl_q.mask;
    assign start_pulse_o = ctl_q.start;
    assign cmd_reject_o  = ctl_q.reject;

endmodule

// File: rtl/sect_erase_batcher_chk.sv
module sect_erase_batcher_chk #(
    parameter int NUM_SECTORS = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sec_cmd_i,
    input logic                   chip_cmd_i,
    input logic                   resume_cmd_i,
    input logic                   erase_done_i,
    input logic                   erasing_o,
    input logic [NUM_SECTORS-1:0] sel_mask_o,
    input logic                   start_pulse_o,
    input logic                   cmd_reject_o,
    input logic                   suspended_o
);

    a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse_o |=> !start_pulse_o);

    a_r3_start_with_status: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse_o |-> (erasing_o && !suspended_o));

    a_r5_chip_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!erasing_o && (sel_mask_o == '0) && chip_cmd_i && !sec_cmd_i)
        |=> (erasing_o && (&sel_mask_o) && start_pulse_o));

    a_r6_reject_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_reject_o && erasing_o) |-> (sel_mask_o == $past(sel_mask_o)));

    a_r7_hold_while_suspended: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended_o && !resume_cmd_i) |=> (suspended_o && erasing_o && $stable(sel_mask_o)));

    a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (erasing_o && !suspended_o && erase_done_i) |=> (!erasing_o && (sel_mask_o == '0)));

endmodule

bind sect_erase_batcher sect_erase_batcher_chk #(
    .NUM_SECTORS (NUM_SECTORS)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sec_cmd_i     (sec_cmd_i),
    .chip_cmd_i    (chip_cmd_i),
    .resume_cmd_i  (resume_cmd_i),
    .erase_done_i  (erase_done_i),
    .erasing_o     (erasing_o),
    .sel_mask_o    (sel_mask_o),
    .start_pulse_o (start_pulse_o),
    .cmd_reject_o  (cmd_reject_o),
    .suspended_o   (suspended_o)
);

// File: tb/sect_erase_batcher_tb_top.sv
`timescale 1ns/1ps
module sect_erase_batcher_tb_top;

    localparam int N  = 8;
    localparam int W  = 20;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sec_cmd = 1'b0;
    logic [IW-1:0] sec_idx = '0;
    logic          chip_cmd = 1'b0;
    logic          susp_cmd = 1'b0;
    logic          resume_cmd = 1'b0;
    logic          other_cmd = 1'b0;
    logic          erase_done = 1'b0;
    logic          erasing;
    logic [N-1:0]  mask;
    logic          start;
    logic          reject;
    logic          suspended;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int         at;
        logic [N-1:0] mask;
        logic       er;
        logic       st;
        logic       rj;
        logic       sp;
        string      req;
    } exp_t;

    exp_t sb_q[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    sect_erase_batcher #(
        .NUM_SECTORS   (N),
        .WINDOW_CYCLES (W)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .sec_cmd_i     (sec_cmd),
        .sec_idx_i     (sec_idx),
        .chip_cmd_i    (chip_cmd),
        .susp_cmd_i    (susp_cmd),
        .resume_cmd_i  (resume_cmd),
        .other_cmd_i   (other_cmd),
        .erase_done_i  (erase_done),
        .erasing_o     (erasing),
        .sel_mask_o    (mask),
        .start_pulse_o (start),
        .cmd_reject_o  (reject),
        .suspended_o   (suspended)
    );

    // Monitor: compare outputs against queued expectations
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (e.at != cyc || mask !== e.mask || erasing !== e.er || start !== e.st
                || reject !== e.rj || suspended !== e.sp) begin
                errors++;
                $display("FAIL %s cyc=%0d: got mask=%h er=%b st=%b rj=%b sp=%b, exp mask=%h er=%b st=%b rj=%b sp=%b (at %0d)",
                         e.req, cyc, mask, erasing, start, reject, suspended,
                         e.mask, e.er, e.st, e.rj, e.sp, e.at);
            end
        end
    end

    task automatic push(input int at, input logic [N-1:0] m, input logic er,
                        input logic st, input logic rj, input logic sp, input string r);
        exp_t e;
        e.at = at; e.mask = m; e.er = er; e.st = st; e.rj = rj; e.sp = sp; e.req = r;
        sb_q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            sec_cmd = 1'b0; chip_cmd = 1'b0; susp_cmd = 1'b0;
            resume_cmd = 1'b0; other_cmd = 1'b0; erase_done = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, exp completion");
        finish_run();
    end

    initial begin
        int c;
        int c2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push(cyc + 1, 8'h00, 0, 0, 0, 0, "R1");
        step(2);

        // R2, R4 restart, R9 reject during window, R3 expiry
        c = cyc; sec_cmd = 1; sec_idx = 3;
        push(c + 1, 8'h08, 0, 0, 0, 0, "R2");
        step(10);
        c2 = cyc; sec_cmd = 1; sec_idx = 5;
        push(c2 + 1, 8'h28, 0, 0, 0, 0, "R4");
        step(5);
        c = cyc; chip_cmd = 1;
        push(c + 1, 8'h28, 0, 0, 1, 0, "R9");
        push(c + 2, 8'h28, 0, 0, 0, 0, "R9");
        push(c2 + W, 8'h28, 0, 0, 0, 0, "R4");
        push(c2 + W + 1, 8'h28, 1, 1, 0, 0, "R3");
        push(c2 + W + 2, 8'h28, 1, 0, 0, 0, "R3");
        step(W);

        // R6 locked phase
        c = cyc; other_cmd = 1;
        push(c + 1, 8'h28, 1, 0, 1, 0, "R6");
        push(c + 2, 8'h28, 1, 0, 0, 0, "R6");
        step(2);
        c = cyc; sec_cmd = 1; sec_idx = 0;
        push(c + 1, 8'h28, 1, 0, 1, 0, "R6");
        step(2);

        // R7 suspend / resume
        c = cyc; susp_cmd = 1;
        push(c + 1, 8'h28, 1, 0, 0, 1, "R7");
        step(3);
        c = cyc; other_cmd = 1;
        push(c + 1, 8'h28, 1, 0, 1, 1, "R7");
        step(2);
        c = cyc; erase_done = 1;
        push(c + 1, 8'h28, 1, 0, 0, 1, "R7");
        step(2);
        c = cyc; resume_cmd = 1;
        push(c + 1, 8'h28, 1, 0, 0, 0, "R7");
        step(2);

        // R8 finish
        c = cyc; erase_done = 1;
        push(c + 1, 8'h00, 0, 0, 0, 0, "R8");
        step(2);

        // R10 idle strobes
        c = cyc; other_cmd = 1; susp_cmd = 1; resume_cmd = 1;
        push(c + 1, 8'h00, 0, 0, 0, 0, "R10");
        step(2);

        // R5 chip erase
        c = cyc; chip_cmd = 1;
        push(c + 1, 8'hFF, 1, 1, 0, 0, "R5");
        push(c + 2, 8'hFF, 1, 0, 0, 0, "R5");
        step(3);

        // R8 done beats suspend
        c = cyc; erase_done = 1; susp_cmd = 1;
        push(c + 1, 8'h00, 0, 0, 0, 0, "R8");
        step(2);

        // R4 sector command on the expiry edge
        c = cyc; sec_cmd = 1; sec_idx = 1;
        push(c + 1, 8'h02, 0, 0, 0, 0, "R2");
        step(W);
        sec_cmd = 1; sec_idx = 6;
        push(c + W + 1, 8'h42, 0, 0, 0, 0, "R4");
        push(c + 2 * W, 8'h42, 0, 0, 0, 0, "R3");
        push(c + 2 * W + 1, 8'h42, 1, 1, 0, 0, "R3");
        step(W + 3);

        // R6 chip erase while locked
        c = cyc; chip_cmd = 1;
        push(c + 1, 8'h42, 1, 0, 1, 0, "R6");
        step(2);
        c = cyc; erase_done = 1;
        push(c + 1, 8'h00, 0, 0, 0, 0, "R8");
        step(4);

        if (sb_q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard: got %0d pending, exp 0", sb_q.size());
        end
        finish_run();
    end

endmodule